// File: doc/BRIEF.md
# Bus Cycle Command Strobe Decoder

This block sits beside a 32-bit processor and turns its bus status outputs into four separate active-low command strobes: memory read, memory write, I/O read and I/O write. It runs on the double-rate bus clock, in which one bus state spans two clock periods. On the clock edge where the active-low address strobe is sampled low, it captures the cycle type from the memory/IO select, the write/read select and the data/control status.

From the next clock it drives exactly one strobe low. That strobe stays low until the ready acknowledge is sampled low at the closing edge of a T2 state. Halt and interrupt-acknowledge cycles, flagged by data/control low, produce no strobe. Address decoding, data buffering and wait-state generation are left to neighbouring logic. The strobes follow the captured cycle type, not the raw status lines, so status changes after the address phase cannot glitch them.

Top module: `strb_dec`

## Requirements
- R1: While reset is low at a clock edge, and after it, all four strobes are high (inactive), even if a cycle was in progress or the address strobe is low.
- R2: When the block is idle, ads_n is low and data_ctl is 1 at a clock edge, one strobe goes low after that edge. The strobe is chosen as follows: mem_io=1, wr_rd=0 gives mem_rd_n; mem_io=1, wr_rd=1 gives mem_wr_n; mem_io=0, wr_rd=0 gives io_rd_n; mem_io=0, wr_rd=1 gives io_wr_n.
- R3: An address strobe with data_ctl=0 (halt or interrupt acknowledge) produces no strobe, and the block stays idle, so the next qualified address strobe is accepted.
- R4: At most one of the four strobes is low in any clock.
- R5: While a cycle is active, the asserted strobe stays the same until it is released. Changes on mem_io, wr_rd and data_ctl have no effect on it.
- R6: Ready is sampled only at the second clock edge of each two-clock bus state counted from capture (edges 2, 4, 6 ... after the capture edge). Ready low at the other edges is ignored.
- R7: Ready low at a sampling edge releases the strobe, so all strobes are high after that edge. Ready high at a sampling edge inserts a wait state of two clocks.
- R8: An address strobe that arrives while a cycle is active is ignored. It neither changes the asserted strobe nor extends the cycle.
- R9: With ads_n held high in the idle state, no strobe is asserted, whatever the status lines show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ads_n | input | 1 | Address strobe, active low |
| mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wr_rd | input | 1 | 1 = write, 0 = read |
| data_ctl | input | 1 | 1 = data transfer, 0 = halt or interrupt acknowledge |
| rdy_n | input | 1 | Ready acknowledge, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |

## Verification
Several properties are checked on every clock:
- at most one strobe is low;
- an idle-time address strobe produces exactly the strobe its latched status selects, or none for a halt or interrupt acknowledge;
- an active strobe holds while no ready is sampled;
- ready at a sampling edge releases the strobe.

Only the directed scenarios can show the following:
- the exact clocks at which strobes fall and rise across several wait states;
- that ready in the first half of T2 is ignored;
- that status changes and a stray address strobe mid-cycle leave the strobe alone;
- that a reset in mid-cycle clears the active strobe.

// File: rtl/strb_dec_pkg.sv
// Package: shared cycle-kind encoding and strobe count for the strobe decoder.
// Assumes: the kind index equals the strobe bit position in the strobe vector.
package strb_dec_pkg;

    localparam int NUM_STROBES = 4;
    localparam int KIND_W      = $clog2(NUM_STROBES);

    // Index = {~mem_io, wr_rd}; also the bit of the strobe vector it drives.
    typedef enum logic [KIND_W-1:0] {
        CYC_MEM_RD = 2'd0,
        CYC_MEM_WR = 2'd1,
        CYC_IO_RD  = 2'd2,
        CYC_IO_WR  = 2'd3
    } cyc_kind_e;

endpackage

// File: rtl/strb_classify.sv
// Module: combinational classifier of the raw processor status lines.
// Assumes: its outputs are used only on an edge where the address strobe is low.
module strb_classify
    import strb_dec_pkg::*;
(
    input  logic      mem_io,
    input  logic      wr_rd,
    input  logic      data_ctl,
    output cyc_kind_e kind,
    output logic      xfer
);

    // Map memory/IO and write/read onto the kind index.
    always_comb begin
        kind = cyc_kind_e'({~mem_io, wr_rd});
        xfer = data_ctl;
    end

endmodule

// File: rtl/strb_tracker.sv
// Module: bus cycle tracker. Latches the cycle kind on a qualified address
// strobe and counts clocks within each bus state. It ends the cycle when
// ready is low at the closing edge of a state.
// Assumes: STATE_CLKS clocks per bus state (2 for a double-rate clock).
module strb_tracker
    import strb_dec_pkg::*;
#(
    parameter int STATE_CLKS = 2
) (
    input  logic      clk2,
    input  logic      rst_n,
    input  logic      ads_n,
    input  logic      rdy_n,
    input  logic      xfer,
    input  cyc_kind_e kind_in,
    output logic      active,
    output cyc_kind_e kind_q,
    output logic      sample_ok
);

    localparam int CW = (STATE_CLKS > 2) ? $clog2(STATE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STATE_CLKS - 1);

    logic [CW-1:0] phase_q;

    // Ready is looked at only on the last clock of a bus state.
    always_comb sample_ok = active && (phase_q == LAST);

    // Cycle capture, state-phase counting and release on ready.
    always_ff @(posedge clk2) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase_q <= '0;
            kind_q  <= CYC_MEM_RD;
        end else if (!active) begin
            if (!ads_n && xfer) begin
                active  <= 1'b1;
                phase_q <= '0;
                kind_q  <= kind_in;
            end
        end else if (sample_ok) begin
            phase_q <= '0;
            if (!rdy_n) begin
                active <= 1'b0;
            end
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/strb_drive.sv
// Module: drives the active-low strobe vector from the latched cycle kind.
// Assumes: kind_q holds steady for the whole time active is high.
module strb_drive
    import strb_dec_pkg::*;
(
    input  logic                   active,
    input  cyc_kind_e              kind_q,
    output logic [NUM_STROBES-1:0] strobe_n
);

    for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strb
        // Pull one strobe low when its kind matches the latched cycle.
        always_comb strobe_n[i] = !(active && (kind_q == cyc_kind_e'(KIND_W'(i))));
    end

endmodule

// File: rtl/strb_dec.sv
// Module: top of the bus cycle command strobe decoder. Turns the processor
// status lines into four active-low command strobes, held from the address
// phase until the ready acknowledge.
// Assumes: a non-pipelined bus on a double-rate clock, with a synchronous
// active-low reset.
module strb_dec
    import strb_dec_pkg::*;
#(
    parameter int STATE_CLKS = 2
) (
    input  logic clk2,
    input  logic rst_n,
    input  logic ads_n,
    input  logic mem_io,
    input  logic wr_rd,
    input  logic data_ctl,
    input  logic rdy_n,
    output logic mem_rd_n,
    output logic mem_wr_n,
    output logic io_rd_n,
    output logic io_wr_n
);

    cyc_kind_e               kind_raw;
    cyc_kind_e               kind_q;
    logic                    xfer;
    logic                    active;
    logic                    sample_ok;
    logic [NUM_STROBES-1:0]  strobe_n;

    strb_classify u_cls (
        .mem_io   (mem_io),
        .wr_rd    (wr_rd),
        .data_ctl (data_ctl),
        .kind     (kind_raw),
        .xfer     (xfer)
    );

    strb_tracker #(.STATE_CLKS(STATE_CLKS)) u_trk (
        .clk2      (clk2),
        .rst_n     (rst_n),
        .ads_n     (ads_n),
        .rdy_n     (rdy_n),
        .xfer      (xfer),
        .kind_in   (kind_raw),
        .active    (active),
        .kind_q    (kind_q),
        .sample_ok (sample_ok)
    );

    strb_drive u_drv (
        .active   (active),
        .kind_q   (kind_q),
        .strobe_n (strobe_n)
    );

    // Fan the strobe vector out to the named command pins.
    always_comb begin
        mem_rd_n = strobe_n[CYC_MEM_RD];
        mem_wr_n = strobe_n[CYC_MEM_WR];
        io_rd_n  = strobe_n[CYC_IO_RD];
        io_wr_n  = strobe_n[CYC_IO_WR];
    end

endmodule

// File: rtl/strb_dec_chk.sv
// Module: assertion checker for the strobe decoder, bound to strb_dec.
// Assumes: strb_n is the pin vector {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n}.
module strb_dec_chk (
    input logic       clk2,
    input logic       rst_n,
    input logic       ads_n,
    input logic       mem_io,
    input logic       wr_rd,
    input logic       data_ctl,
    input logic       rdy_n,
    input logic       sample_ok,
    input logic [3:0] strb_n
);

    AST_ONE_HOT: assert property (@(posedge clk2) disable iff (!rst_n)
        $countones(~strb_n) <= 1);                                                   // R4

    AST_START_TYPE: assert property (@(posedge clk2) disable iff (!rst_n)
        (&strb_n && !ads_n && data_ctl)
        |=> (strb_n == ~(4'b0001 << {~$past(mem_io), $past(wr_rd)})));              // R2

    AST_NO_CTRL_STROBE: assert property (@(posedge clk2) disable iff (!rst_n)
        (&strb_n && !ads_n && !data_ctl) |=> &strb_n);                              // R3

    AST_IDLE_QUIET: assert property (@(posedge clk2) disable iff (!rst_n)
        (&strb_n && ads_n) |=> &strb_n);                                            // R9

    AST_HOLD: assert property (@(posedge clk2) disable iff (!rst_n)
        (!(&strb_n) && !(sample_ok && !rdy_n)) |=> $stable(strb_n));                // R5

    AST_RELEASE: assert property (@(posedge clk2) disable iff (!rst_n)
        (!(&strb_n) && sample_ok && !rdy_n) |=> &strb_n);                           // R7

    AST_FIRST_HALF: assert property (@(posedge clk2) disable iff (!rst_n)
        ($past(&strb_n) && !(&strb_n)) |-> !sample_ok);                             // R6

endmodule

bind strb_dec strb_dec_chk u_chk (
    .clk2      (clk2),
    .rst_n     (rst_n),
    .ads_n     (ads_n),
    .mem_io    (mem_io),
    .wr_rd     (wr_rd),
    .data_ctl  (data_ctl),
    .rdy_n     (rdy_n),
    .sample_ok (sample_ok),
    .strb_n    (strobe_n)
);

// File: tb/strb_dec_tb.sv
module strb_dec_tb;

    logic clk2 = 1'b0;
    logic rst_n = 1'b0;
    logic ads_n = 1'b1;
    logic mem_io = 1'b1;
    logic wr_rd = 1'b0;
    logic data_ctl = 1'b1;
    logic rdy_n = 1'b1;
    logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk2 = ~clk2;

    strb_dec u_dut (
        .clk2     (clk2),
        .rst_n    (rst_n),
        .ads_n    (ads_n),
        .mem_io   (mem_io),
        .wr_rd    (wr_rd),
        .data_ctl (data_ctl),
        .rdy_n    (rdy_n),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .io_rd_n  (io_rd_n),
        .io_wr_n  (io_wr_n)
    );

    function automatic logic [3:0] exp_for(input logic mio, input logic wr);
        return ~(4'b0001 << {~mio, wr});
    endfunction

    // Compare the strobe pins {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n}; also check R4.
    task automatic chk(input logic [3:0] exp, input string req);
        logic [3:0] act;
        act = {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: strobes actual %b expected %b", req, act, exp);
        end
        n_chk++;
        if ($countones(~act) > 1) begin
            n_fail++;
            $display("FAIL R4: low strobes actual %0d expected <=1", $countones(~act));
        end
    endtask

    // One bus cycle; every check is made at a falling edge.
    task automatic run_cycle(input logic mio, input logic wr, input logic dc,
                             input int waits, input bit early, input bit busy,
                             input string req);
        logic [3:0] e;
        e = dc ? exp_for(mio, wr) : 4'hF;
        @(negedge clk2);
        ads_n = 1'b0; mem_io = mio; wr_rd = wr; data_ctl = dc; rdy_n = 1'b1;
        @(negedge clk2);
        chk(e, req);
        if (!dc) begin
            ads_n = 1'b1; rdy_n = 1'b0;
            @(negedge clk2);
            chk(4'hF, req);
            rdy_n = 1'b1;
            return;
        end
        ads_n = busy ? 1'b0 : 1'b1;
        mem_io = ~mio; wr_rd = ~wr; data_ctl = 1'b1;
        rdy_n = early ? 1'b0 : 1'b1;
        @(negedge clk2);
        chk(e, req);
        ads_n = 1'b1;
        rdy_n = (waits == 0) ? 1'b0 : 1'b1;
        for (int w = 0; w < waits; w++) begin
            @(negedge clk2);
            chk(e, req);
            rdy_n = 1'b1;
            @(negedge clk2);
            chk(e, req);
            rdy_n = (w == waits - 1) ? 1'b0 : 1'b1;
        end
        @(negedge clk2);
        chk(4'hF, {req, " release R7"});
        rdy_n = 1'b1;
    endtask

    task automatic t_reset();
        ads_n = 1'b0; rdy_n = 1'b1;
        repeat (3) @(negedge clk2);
        chk(4'hF, "R1 during reset");
        ads_n = 1'b1; rst_n = 1'b1;
        @(negedge clk2);
        chk(4'hF, "R1 after reset");
        ads_n = 1'b0; mem_io = 1'b0; wr_rd = 1'b1; data_ctl = 1'b1;
        @(negedge clk2);
        chk(exp_for(1'b0, 1'b1), "R2 before mid-cycle reset");
        ads_n = 1'b1; rst_n = 1'b0;
        @(negedge clk2);
        chk(4'hF, "R1 mid-cycle reset");
        rst_n = 1'b1;
        @(negedge clk2);
        chk(4'hF, "R1 stays idle");
    endtask

    task automatic t_all_combos();
        for (int c = 0; c < 8; c++) begin
            run_cycle(c[2], c[1], c[0], 0, 1'b0, 1'b0, "R2/R3 combo");
        end
    endtask

    task automatic t_waits();
        run_cycle(1'b1, 1'b0, 1'b1, 1, 1'b0, 1'b0, "R7 one wait");
        run_cycle(1'b0, 1'b1, 1'b1, 3, 1'b0, 1'b0, "R5 three waits");
    endtask

    task automatic t_early_ready();
        run_cycle(1'b0, 1'b0, 1'b1, 0, 1'b1, 1'b0, "R6 early ready");
        run_cycle(1'b1, 1'b1, 1'b1, 2, 1'b1, 1'b0, "R6 early ready waits");
    endtask

    task automatic t_busy_ads();
        run_cycle(1'b1, 1'b1, 1'b1, 1, 1'b0, 1'b1, "R8 busy ads");
    endtask

    task automatic t_no_ads();
        ads_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk2);
            mem_io = c[1]; wr_rd = c[0]; data_ctl = 1'b1; rdy_n = c[0];
            @(negedge clk2);
            chk(4'hF, "R9 no ads");
        end
    endtask

    task automatic t_halt_then_go();
        run_cycle(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R3 halt");
        run_cycle(1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R3 accepted after halt");
    endtask

    initial begin
        t_reset();
        t_all_combos();
        t_waits();
        t_early_ready();
        t_busy_ads();
        t_no_ads();
        t_halt_then_go();
        repeat (2) @(negedge clk2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk2);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..R9: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule